// File: doc/BRIEF.md
# Multi-Element Radix Carry Propagator

This block adds two vectors of digits, element by element. Every element holds one digit in a radix chosen at run time, and the radix need not be a power of two. A carry may pass from any element into the next. The block does not ripple that carry through the chain. Each element works out on its own whether it creates a carry or only passes one along. Those flags are packed into two integers, and one wide addition then gives the carry into every element at once.

An incoming carry enters at the bottom of the chain. The carry that leaves the top element is reported. A flag tells whether any carry moved between elements or out of the top. The caller presents a request with a valid strobe, and the registered result appears one cycle later. The caller must keep every input digit below the radix and must give a radix of at least 2.

Top module: `mrad_carry_add`

## Requirements
- R1: After reset is asserted (active low), `valid_o`, `sum_o`, `cout_o` and `prop_o` are all 0.
- R2: A request accepted with `valid_i` high gives `valid_o` high on the next clock edge. A cycle with `valid_i` low drives `valid_o` low, and `sum_o`, `cout_o` and `prop_o` keep their previous values.
- R3: Element i of the packed vectors occupies bits [i*DIG_W +: DIG_W], and element 0 is the least significant digit. Each result digit equals (A[i] + B[i] + carry into element i) mod radix. The carry into element 0 is `cin_i`.
- R4: A carry crosses any run of elements whose digit sum is exactly radix-1. When every element sums to radix-1 and `cin_i` is 1, all result digits are 0 and `cout_o` is 1.
- R5: `cout_o` is 1 exactly when the total A + B + cin, read as numbers in the given radix, reaches radix^N_ELEM or more.
- R6: `prop_o` is 1 exactly when a carry leaves at least one element, into the next element or out as `cout_o`. A carry entering element 0 from `cin_i` alone does not set it.
- R7: An element whose digit sum is exactly radix-1, and which receives no incoming carry, outputs radix-1 and passes no carry on.
- R8: Radix values from 2 up to 2^DIG_W work, including values that are not powers of two and the full value 2^DIG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| a_i | input | N_ELEM*DIG_W | First operand digits |
| b_i | input | N_ELEM*DIG_W | Second operand digits |
| cin_i | input | 1 | Carry into element 0 |
| radix_i | input | DIG_W+1 | Radix of every element, 2 to 2^DIG_W |
| valid_o | output | 1 | Result valid, one cycle after the request |
| sum_o | output | N_ELEM*DIG_W | Result digits |
| cout_o | output | 1 | Carry out of the top element |
| prop_o | output | 1 | Set when any carry left any element |

## Verification
The directed cases cover the hard carry patterns. A carry must cross a full chain of radix-1 digits in radix 10 and radix 16. A design that resolved only one level of carry would leave stale nines there and lose `cout_o`. An element summing to exactly radix-1 with no carry in checks that P is not counted as G. A design that confused the two would wrap that digit to zero and invent a carry. `cin_i` alone is applied to all-zero operands, which must leave `prop_o` clear. Random vectors over odd radices such as 3 and 7 catch a modulo stage that masks bits instead of subtracting the radix.

// File: rtl/mrad_pkg.sv
package mrad_pkg;
    localparam int unsigned DEF_N_ELEM = 8;
    localparam int unsigned DEF_DIG_W  = 4;
endpackage

// File: rtl/mrad_elem.sv
module mrad_elem #(
    parameter int unsigned DIG_W = 4,
    localparam int unsigned RAD_W = DIG_W + 1
) (
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    input  logic [RAD_W-1:0] radix_i,
    output logic [DIG_W:0]   sum_o,
    output logic             gen_o,
    output logic             prop_o
);
    logic [RAD_W-1:0] top_digit;

    always_comb begin
        sum_o     = {1'b0, a_i} + {1'b0, b_i};
        top_digit = radix_i - 1'b1;
        gen_o     = sum_o > top_digit;
        prop_o    = sum_o == top_digit;
    end
endmodule

// File: rtl/mrad_resolve.sv
module mrad_resolve #(
    parameter int unsigned N_ELEM = 8
) (
    input  logic [N_ELEM-1:0] gen_i,
    input  logic [N_ELEM-1:0] prop_i,
    input  logic              cin_i,
    output logic [N_ELEM-1:0] carry_o,
    output logic              cout_o,
    output logic              moved_o
);
    localparam int unsigned EXT_W = N_ELEM + 1;

    logic [EXT_W-1:0] p_ext, g_ext;
    logic [EXT_W:0]   total, resolved;

    always_comb begin
        // the carry-in sits as a generate one position below element 0
        p_ext    = {prop_i, 1'b0};
        g_ext    = {gen_i, cin_i};
        total    = {1'b0, p_ext | g_ext} + {1'b0, g_ext};
        resolved = total ^ {1'b0, p_ext};
        carry_o  = resolved[N_ELEM:1];
        cout_o   = resolved[N_ELEM+1];
        moved_o  = |resolved[N_ELEM+1:2];
    end
endmodule

// File: rtl/mrad_wrap.sv
module mrad_wrap #(
    parameter int unsigned DIG_W = 4,
    localparam int unsigned RAD_W = DIG_W + 1
) (
    input  logic [DIG_W:0]   sum_i,
    input  logic             carry_i,
    input  logic [RAD_W-1:0] radix_i,
    output logic [DIG_W-1:0] digit_o
);
    logic [DIG_W+1:0] full, reduced;

    always_comb begin
        full    = {1'b0, sum_i} + {{(DIG_W+1){1'b0}}, carry_i};
        reduced = full - {1'b0, radix_i};
        digit_o = (full >= {1'b0, radix_i}) ? reduced[DIG_W-1:0] : full[DIG_W-1:0];
    end
endmodule

// File: rtl/mrad_carry_add.sv
module mrad_carry_add #(
    parameter int unsigned N_ELEM = mrad_pkg::DEF_N_ELEM,
    parameter int unsigned DIG_W  = mrad_pkg::DEF_DIG_W,
    localparam int unsigned RAD_W = DIG_W + 1,
    localparam int unsigned VEC_W = N_ELEM * DIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic             cin_i,
    input  logic [RAD_W-1:0] radix_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] sum_o,
    output logic             cout_o,
    output logic             prop_o
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] sum;
        logic             cout;
        logic             prop;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [N_ELEM-1:0] gen_w, prop_w, carry_w;
    logic [DIG_W:0]    elem_sum_w [N_ELEM];
    logic [VEC_W-1:0]  digits_w;
    logic              cout_w, moved_w;

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_elem
        mrad_elem #(.DIG_W(DIG_W)) elem_i (
            .a_i     (a_i[gi*DIG_W +: DIG_W]),
            .b_i     (b_i[gi*DIG_W +: DIG_W]),
            .radix_i (radix_i),
            .sum_o   (elem_sum_w[gi]),
            .gen_o   (gen_w[gi]),
            .prop_o  (prop_w[gi])
        );

        mrad_wrap #(.DIG_W(DIG_W)) wrap_i (
            .sum_i   (elem_sum_w[gi]),
            .carry_i (carry_w[gi]),
            .radix_i (radix_i),
            .digit_o (digits_w[gi*DIG_W +: DIG_W])
        );
    end

    mrad_resolve #(.N_ELEM(N_ELEM)) resolve_i (
        .gen_i   (gen_w),
        .prop_i  (prop_w),
        .cin_i   (cin_i),
        .carry_o (carry_w),
        .cout_o  (cout_w),
        .moved_o (moved_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = valid_i;
        if (valid_i) begin
            state_d.sum  = digits_w;
            state_d.cout = cout_w;
            state_d.prop = moved_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign valid_o = state_q.valid;
    assign sum_o   = state_q.sum;
    assign cout_o  = state_q.cout;
    assign prop_o  = state_q.prop;
endmodule

// File: rtl/mrad_carry_add_chk.sv
module mrad_carry_add_chk #(
    parameter int unsigned N_ELEM = 8,
    parameter int unsigned DIG_W  = 4,
    localparam int unsigned RAD_W = DIG_W + 1,
    localparam int unsigned VEC_W = N_ELEM * DIG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [VEC_W-1:0] a_i,
    input logic [VEC_W-1:0] b_i,
    input logic             cin_i,
    input logic [RAD_W-1:0] radix_i,
    input logic             valid_o,
    input logic [VEC_W-1:0] sum_o,
    input logic             cout_o,
    input logic             prop_o
);
    logic [RAD_W-1:0] seen_radix_q;
    logic             digits_ok;
    logic             zero_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_radix_q <= '0;
        else if (valid_i) seen_radix_q <= radix_i;
    end

    always_comb begin
        digits_ok = 1'b1;
        for (int i = 0; i < int'(N_ELEM); i++) begin
            if ({1'b0, sum_o[i*DIG_W +: DIG_W]} >= seen_radix_q) digits_ok = 1'b0;
        end
        zero_req = valid_i && (a_i == '0) && (b_i == '0);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(sum_o) && $stable(cout_o) && $stable(prop_o))); // R2
    AST_DIGIT_BELOW_RADIX: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> digits_ok); // R3
    AST_COUT_IMPLIES_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cout_o) |-> prop_o); // R6
    AST_ZERO_NO_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (!prop_o && !cout_o)); // R6
endmodule

bind mrad_carry_add mrad_carry_add_chk #(.N_ELEM(N_ELEM), .DIG_W(DIG_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .radix_i (radix_i),
    .valid_o (valid_o),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .prop_o  (prop_o)
);

// File: tb/mrad_carry_add_tb_top.sv
module mrad_carry_add_tb_top;
    localparam int N_ELEM   = 8;
    localparam int DIG_W    = 4;
    localparam int RAD_W    = DIG_W + 1;
    localparam int VEC_W    = N_ELEM * DIG_W;
    localparam int CLK_HALF = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_i = 1'b0;
    logic [VEC_W-1:0] a_i = '0, b_i = '0;
    logic             cin_i = 1'b0;
    logic [RAD_W-1:0] radix_i = 5'd10;
    logic             valid_o, cout_o, prop_o;
    logic [VEC_W-1:0] sum_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #CLK_HALF clk = ~clk;

    mrad_carry_add #(.N_ELEM(N_ELEM), .DIG_W(DIG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
        .cin_i(cin_i), .radix_i(radix_i), .valid_o(valid_o), .sum_o(sum_o),
        .cout_o(cout_o), .prop_o(prop_o)
    );

    // reference: digit-serial ripple, independent of the packed method
    function automatic void ref_add(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                                    input logic ci, input int r,
                                    output logic [VEC_W-1:0] s, output logic co,
                                    output logic pr);
        int c = ci;
        pr = 1'b0;
        s  = '0;
        for (int i = 0; i < N_ELEM; i++) begin
            int t = int'(a[i*DIG_W +: DIG_W]) + int'(b[i*DIG_W +: DIG_W]) + c;
            if (t >= r) begin t = t - r; c = 1; end else c = 0;
            if (c == 1) pr = 1'b1;
            s[i*DIG_W +: DIG_W] = t[DIG_W-1:0];
        end
        co = c[0];
    endfunction

    function automatic logic [VEC_W-1:0] fill(input int d);
        logic [VEC_W-1:0] v = '0;
        for (int i = 0; i < N_ELEM; i++) v[i*DIG_W +: DIG_W] = d[DIG_W-1:0];
        return v;
    endfunction

    task automatic apply(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                         input logic ci, input int r, input string tag);
        logic [VEC_W-1:0] es;
        logic eco, epr;
        ref_add(a, b, ci, r, es, eco, epr);
        @(negedge clk);
        a_i = a; b_i = b; cin_i = ci; radix_i = r[RAD_W-1:0]; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        n_vec++;
        if (valid_o !== 1'b1 || sum_o !== es || cout_o !== eco || prop_o !== epr) begin
            n_fail++;
            $display("FAIL %s: valid=%b sum=%h cout=%b prop=%b expected valid=1 sum=%h cout=%b prop=%b",
                     tag, valid_o, sum_o, cout_o, prop_o, es, eco, epr);
        end
    endtask

    task automatic idle_hold;
        logic [VEC_W-1:0] ks = sum_o;
        logic kc = cout_o, kp = prop_o;
        a_i = $urandom; b_i = $urandom; cin_i = 1'b1;
        @(negedge clk);
        n_vec++;
        if (valid_o !== 1'b0 || sum_o !== ks || cout_o !== kc || prop_o !== kp) begin
            n_fail++;
            $display("FAIL R2 hold: valid=%b sum=%h cout=%b prop=%b expected valid=0 sum=%h cout=%b prop=%b",
                     valid_o, sum_o, cout_o, prop_o, ks, kc, kp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        n_vec++;
        if (valid_o !== 1'b0 || sum_o !== '0 || cout_o !== 1'b0 || prop_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: valid=%b sum=%h cout=%b prop=%b expected all 0",
                     valid_o, sum_o, cout_o, prop_o);
        end
        rst_n = 1'b1;

        apply(fill(9), fill(0), 1'b1, 10, "R4 nines radix 10");
        apply(fill(15), fill(0), 1'b1, 16, "R4 full chain radix 16");
        idle_hold();
        apply(fill(4), fill(5), 1'b0, 10, "R7 sum radix-1 no carry");
        apply(fill(0), fill(0), 1'b1, 10, "R6 cin alone");
        apply(fill(0), fill(0), 1'b0, 7, "R6 zeros");
        apply(fill(2), fill(2), 1'b0, 3, "R5 all generate radix 3");
        apply(fill(1), fill(0), 1'b1, 2, "R4 radix 2 chain");
        apply(fill(8), fill(7), 1'b0, 16, "R8 radix 16 no carry");
        idle_hold();
        // generate at element 0 crossing a propagate run up to the top
        apply({{(N_ELEM-1){4'd3}}, 4'd5}, {{(N_ELEM-1){4'd3}}, 4'd5}, 1'b0, 7, "R5 run to top radix 7");

        for (int k = 0; k < 300; k++) begin
            int r = 2 + int'($urandom % 15);
            logic [VEC_W-1:0] a = '0, b = '0;
            for (int i = 0; i < N_ELEM; i++) begin
                int da = int'($urandom % r);
                int db = ((k % 4) == 0) ? (r - 1 - da) : int'($urandom % r);
                a[i*DIG_W +: DIG_W] = da[DIG_W-1:0];
                b[i*DIG_W +: DIG_W] = db[DIG_W-1:0];
            end
            apply(a, b, $urandom % 2, r, "R3 random");
            if (k % 50 == 0) idle_hold();
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule